// File: doc/BRIEF.md
# Five-State Table-Driven Mealy Sequencer

This block is a synchronous sequential circuit with one serial input and one output. It holds a 3-bit state code and moves through five legal codes according to a fixed transition table on every rising clock edge. The output is a Mealy output: it is computed combinationally from the present state code and the current input bit. Within a cycle it therefore follows any change of the input without waiting for a clock edge.

The state register uses D-type next-state logic. Its code is brought out on a port so that the sequence can be observed. The three codes outside the table (101, 110, 111) are handled safely: they drive the output low and fall back to 000 on the next edge. A synchronous reset loads a parameterised start code, which is 000 by default. A user samples the output late in each cycle, after the input has settled, because an input change can make the output glitch briefly.

Top module: `mealy5_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the state loads `RESET_CODE` (default 000) on that edge, regardless of `xIn`.
- R2: In state 000, input 0 gives `zOut`=0 and next state 011; input 1 gives `zOut`=1 and next state 010.
- R3: In state 001, input 0 gives `zOut`=1 and next state 000; input 1 gives `zOut`=0 and next state 010.
- R4: In state 010, the next state is 100 for either input, and `zOut` equals the input bit.
- R5: In state 011, input 0 gives `zOut`=1 and next state 010; input 1 gives `zOut`=0 and next state 000.
- R6: In state 100, input 0 gives `zOut`=0 and the state stays at 100; input 1 gives `zOut`=1 and next state 000.
- R7: In any of the codes 101, 110 and 111, `zOut` is 0 for both input values and the next state is 000.
- R8: `zOut` responds to a change of `xIn` within the same clock cycle, with no clock edge in between, and `stateOut` does not change in that time.
- R9: Starting from 000 and applying the inputs 0,1,1,0,1 on successive edges, the settled outputs are 0,0,1,0,1 and the states visited after each edge are 011,000,010,100,000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xIn | input | 1 | Serial input bit |
| zOut | output | 1 | Mealy output, combinational in state and input |
| stateOut | output | 3 | Present state code, bit 2 first (ABC order) |

## Verification
The directed sequence 0,1,1,0,1 from 000 sets the expected trace against the table. A fixed-seed random stream with occasional resets then covers every legal code under both input values, and any swapped row or output shows up there. Extra instances whose reset code is 001 or one of the unused codes reach states that the main instance cannot reach from 000, and they tell the recovery path apart from normal transitions. A mid-cycle toggle of the input shows that the output is combinational rather than registered.

// File: rtl/mealy5_pkg.sv
`timescale 1ns/1ps
package mealy5_pkg;
  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t S_HOME = 3'b000;
  localparam code_t S_ODD  = 3'b001;
  localparam code_t S_MID  = 3'b010;
  localparam code_t S_ALT  = 3'b011;
  localparam code_t S_PARK = 3'b100;

  // strobes from control to the state datapath
  typedef struct packed {
    logic  clear;
    logic  load;
    code_t nextCode;
  } ctrl_t;
endpackage

// File: rtl/mealy5_ctrl.sv
`timescale 1ns/1ps
module mealy5_ctrl
  import mealy5_pkg::*;
(
  input  logic  rst,
  input  logic  xIn,
  input  code_t curState,
  output ctrl_t ctrl,
  output logic  zOut
);
  code_t nextCode;
  logic  zVal;

  // transition and output table; unused codes recover to home with z low
  always_comb begin
    nextCode = S_HOME;
    zVal     = 1'b0;
    unique case (curState)
      S_HOME: begin nextCode = xIn ? S_MID  : S_ALT;  zVal = xIn;  end
      S_ODD:  begin nextCode = xIn ? S_MID  : S_HOME; zVal = !xIn; end
      S_MID:  begin nextCode = S_PARK;                zVal = xIn;  end
      S_ALT:  begin nextCode = xIn ? S_HOME : S_MID;  zVal = !xIn; end
      S_PARK: begin nextCode = xIn ? S_HOME : S_PARK; zVal = xIn;  end
      default: begin nextCode = S_HOME;               zVal = 1'b0; end
    endcase
  end

  always_comb begin
    ctrl.clear    = rst;
    ctrl.load     = !rst;
    ctrl.nextCode = nextCode;
  end

  assign zOut = zVal;
endmodule

// File: rtl/mealy5_state.sv
`timescale 1ns/1ps
module mealy5_state
  import mealy5_pkg::*;
#(
  parameter code_t RESET_CODE = 3'b000
)(
  input  logic  clk,
  input  ctrl_t ctrl,
  output code_t curState
);
  code_t stateQ;

  always_ff @(posedge clk) begin
    if (ctrl.clear)     stateQ <= RESET_CODE;
    else if (ctrl.load) stateQ <= ctrl.nextCode;
  end

  assign curState = stateQ;
endmodule

// File: rtl/mealy5_seq.sv
`timescale 1ns/1ps
module mealy5_seq
  import mealy5_pkg::*;
#(
  parameter logic [2:0] RESET_CODE = 3'b000
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       xIn,
  output logic       zOut,
  output logic [2:0] stateOut
);
  ctrl_t ctrl;
  code_t curState;

  mealy5_ctrl u_ctrl (
    .rst      (rst),
    .xIn      (xIn),
    .curState (curState),
    .ctrl     (ctrl),
    .zOut     (zOut)
  );

  mealy5_state #(.RESET_CODE(RESET_CODE)) u_state (
    .clk      (clk),
    .ctrl     (ctrl),
    .curState (curState)
  );

  assign stateOut = curState;
endmodule

// File: rtl/mealy5_chk.sv
`timescale 1ns/1ps
module mealy5_chk #(
  parameter logic [2:0] RESET_CODE = 3'b000
)(
  input logic       clk,
  input logic       rst,
  input logic       xIn,
  input logic       zOut,
  input logic [2:0] stateOut
);
  p_reset_load_r1: assert property (@(posedge clk) rst |=> stateOut == RESET_CODE);

  p_home_next_r2: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b000) |=> (stateOut == 3'b011 || stateOut == 3'b010));

  p_odd_out_r3: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b001) |-> (zOut == !xIn));

  p_mid_next_r4: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b010) |=> (stateOut == 3'b100));

  p_alt_out_r5: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b011) |-> (zOut == !xIn));

  p_park_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 3'b100 && !xIn) |=> (stateOut == 3'b100));

  p_unused_recover_r7: assert property (@(posedge clk) disable iff (rst)
    (stateOut[2] && stateOut[1:0] != 2'b00) |=> (stateOut == 3'b000));

  p_unused_zlow_r7: assert property (@(posedge clk) disable iff (rst)
    (stateOut[2] && stateOut[1:0] != 2'b00) |-> !zOut);
endmodule

bind mealy5_seq mealy5_chk #(.RESET_CODE(RESET_CODE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .xIn      (xIn),
  .zOut     (zOut),
  .stateOut (stateOut)
);

// File: tb/mealy5_seq_tb.sv
`timescale 1ns/1ps
module mealy5_seq_tb;
  localparam int N_ALT = 4;
  localparam logic [2:0] ALT_CODE [N_ALT] = '{3'b001, 3'b101, 3'b110, 3'b111};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic x   = 1'b0;
  logic       z;
  logic [2:0] st;
  logic       zAlt  [N_ALT];
  logic [2:0] stAlt [N_ALT];

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;
  logic [2:0] expMain;
  logic [2:0] expAlt [N_ALT];

  always #2 clk = ~clk;  // 250 MHz

  mealy5_seq u_dut (.clk(clk), .rst(rst), .xIn(x), .zOut(z), .stateOut(st));

  for (genvar g = 0; g < N_ALT; g++) begin : g_alt
    mealy5_seq #(.RESET_CODE(ALT_CODE[g])) u_alt (
      .clk(clk), .rst(rst), .xIn(x), .zOut(zAlt[g]), .stateOut(stAlt[g]));
  end

  function automatic logic [2:0] nextOf(input logic [2:0] s, input logic xv);
    case (s)
      3'b000: return xv ? 3'b010 : 3'b011;
      3'b001: return xv ? 3'b010 : 3'b000;
      3'b010: return 3'b100;
      3'b011: return xv ? 3'b000 : 3'b010;
      3'b100: return xv ? 3'b000 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic zOf(input logic [2:0] s, input logic xv);
    case (s)
      3'b000, 3'b010, 3'b100: return xv;
      3'b001, 3'b011:         return !xv;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] s);
    case (s)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // enters at posedge+1; leaves at the following posedge+1
  task automatic doReset();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    expMain = 3'b000;
    chk("R1", "main state after reset", st, 3'b000);
    for (int i = 0; i < N_ALT; i++) begin
      expAlt[i] = ALT_CODE[i];
      chk("R1", "alt state after reset", stAlt[i], ALT_CODE[i]);
    end
  endtask

  task automatic step(input logic xv, input string tag);
    string t;
    x = xv;
    #2;  // settled, one time unit before the edge
    t = (tag == "") ? reqOf(expMain) : tag;
    chk(t, "main z", z, zOf(expMain, xv));
    for (int i = 0; i < N_ALT; i++)
      chk(reqOf(expAlt[i]), "alt z", zAlt[i], zOf(expAlt[i], xv));
    @(posedge clk); #1;
    expMain = nextOf(expMain, xv);
    chk(t, "main state", st, expMain);
    for (int i = 0; i < N_ALT; i++) begin
      expAlt[i] = nextOf(expAlt[i], xv);
      chk("R7", "alt state", stAlt[i], expAlt[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(posedge clk); #1;

    doReset();
    // R9: directed sequence from home
    step(1'b0, "R9"); chk("R9", "state", st, 3'b011);
    step(1'b1, "R9"); chk("R9", "state", st, 3'b000);
    step(1'b1, "R9"); chk("R9", "state", st, 3'b010);
    step(1'b0, "R9"); chk("R9", "state", st, 3'b100);
    step(1'b1, "R9"); chk("R9", "state", st, 3'b000);

    // R8: mid-cycle input toggle with no clock edge
    doReset();
    x = 1'b0; #0.5;
    chk("R8", "z with x=0", z, 0);
    chk("R8", "alt001 z with x=0", zAlt[0], 1);
    x = 1'b1; #0.5;
    chk("R8", "z with x=1", z, 1);
    chk("R8", "alt001 z with x=1", zAlt[0], 0);
    chk("R8", "state stable", st, 3'b000);
    x = 1'b0; #0.5;
    chk("R8", "z back to 0", z, 0);
    #0.5;

    // R1: reset held with x=1 still loads the reset code
    x = 1'b1;
    doReset();
    step(1'b0, "");  // covers alt 001 with x=0 and unused codes
    doReset();
    step(1'b1, "");  // covers alt 001 with x=1

    // R6: park holds under x=0
    doReset();
    step(1'b1, ""); step(1'b0, ""); step(1'b0, ""); step(1'b0, "R6");

    // random stream
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 40) == 0) doReset();
      else step(1'($urandom % 2), "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule